// File: doc/BRIEF.md
# Local Exclusive Access Monitor

This block guards store-conditional writes for a single processor. It sits next to the data memory write port and observes exclusive loads, stores (ordinary or exclusive), an explicit clear request and an exception-entry strobe. It keeps a one-bit reservation state and a tag that holds the reservation address at a coarse granule. An exclusive store reaches memory only while a reservation covering its address is held. The store's status is 0 when it succeeds and 1 when it fails.

The reservation state machine has two states. `MON_OPEN` means no reservation is held. `MON_EXCL` means the tag register holds a live reservation. The transitions are named as follows:
- `T_RESERVE`: any state goes to `MON_EXCL` on an exclusive load. The load records a new tag and does not look at the current state.
- `T_CONSUME`: any state goes to `MON_OPEN` on an exclusive store, whether the store succeeds or fails.
- `T_FLUSH`: any state goes to `MON_OPEN` on a clear request or on exception entry.
- `T_HOLD`: the state is unchanged on idle cycles and on ordinary stores.

When several requests arrive in one cycle, they take effect in this order of priority: `T_FLUSH`, then `T_RESERVE`, then `T_CONSUME`, then `T_HOLD`. An exclusive store is always judged against the state held at the start of its cycle.

Top module: `excl_monitor`

## Requirements
- R1: After reset the monitor is open, so an exclusive store without a preceding exclusive load fails with status 1 and `mem_we` low.
- R2: An exclusive load always reserves, even when the monitor is already exclusive. The most recent exclusive load's address is the one compared.
- R3: The tag keeps only address bits [ADDR_W-1:GRAN_LOG2] (bits [31:3] by default, an 8-byte granule). A store anywhere in the same granule as the load matches. A store in any other granule does not match.
- R4: An exclusive store with a reservation held and a matching address drives `mem_we` high with `mem_addr`/`mem_wdata` equal to the store's address and data, and returns status 0.
- R5: A failed exclusive store returns status 1 with `mem_we` low. This includes a mismatched address while exclusive. `st_status_valid` is high exactly in cycles that carry an exclusive store.
- R6: A clear request returns the monitor to open, so the next exclusive store fails. A clear in the same cycle as an exclusive store also makes that store fail.
- R7: Exception entry returns the monitor to open, so a store-conditional after it fails. Exception entry in the same cycle as an exclusive store also makes that store fail.
- R8: Every exclusive store, successful or not, leaves the monitor open, so a second exclusive store to the same address fails.
- R9: An ordinary store writes memory unconditionally (`mem_we` high, `st_status_valid` low) and does not change the reservation, so a following exclusive store still succeeds.
- R10: An exclusive load and an exclusive store in the same cycle: the store is judged on the old state, and the load's reservation stands afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_excl | input | 1 | Exclusive load request this cycle |
| ld_addr | input | ADDR_W | Exclusive load address |
| st_valid | input | 1 | Store request this cycle |
| st_excl | input | 1 | Store is exclusive (1) or ordinary (0) |
| st_addr | input | ADDR_W | Store address |
| st_data | input | DATA_W | Store data |
| clr_req | input | 1 | Clear reservation request |
| exc_entry | input | 1 | Exception-entry strobe |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory write address |
| mem_wdata | output | DATA_W | Memory write data |
| st_status_valid | output | 1 | Status output is meaningful (exclusive store) |
| st_status | output | 1 | 0 = success, 1 = failure |

## Verification
The tag comparison is swept across every byte offset of a load within one granule, paired with store offsets that reach more than a granule below and above the load. This separates a correct granule boundary from a compare that is one bit too wide or too narrow. Short sequences cover the remaining paths. Load-store-store separates a monitor that stays reserved from one that consumes its reservation. Load followed by clear, by exception entry, or by an ordinary store separates the flushing events from a neutral store. A pair of loads to different granules shows that the tag is replaced and not kept from the first load. Same-cycle combinations fix the stated priority order.

// File: rtl/excl_mon_pkg.sv
package excl_mon_pkg;
    typedef enum logic {
        MON_OPEN = 1'b0,
        MON_EXCL = 1'b1
    } mon_state_e;

    typedef enum logic [1:0] {
        T_HOLD    = 2'd0,
        T_CONSUME = 2'd1,
        T_RESERVE = 2'd2,
        T_FLUSH   = 2'd3
    } mon_trans_e;
endpackage

// File: rtl/excl_mon_fsm.sv
module excl_mon_fsm
    import excl_mon_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reserve,
    input  logic       consume,
    input  logic       flush,
    output mon_state_e state,
    output logic       is_excl
);
    mon_trans_e trans;
    mon_state_e state_nx;

    always_comb begin
        if (flush)        trans = T_FLUSH;
        else if (reserve) trans = T_RESERVE;
        else if (consume) trans = T_CONSUME;
        else              trans = T_HOLD;
    end

    always_comb begin
        state_nx = state;
        unique case (trans)
            T_FLUSH:   state_nx = MON_OPEN;
            T_RESERVE: state_nx = MON_EXCL;
            T_CONSUME: state_nx = MON_OPEN;
            T_HOLD:    state_nx = state;
            default:   state_nx = MON_OPEN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= MON_OPEN;
        else        state <= state_nx;
    end

    always_comb begin
        unique case (state)
            MON_OPEN: is_excl = 1'b0;
            MON_EXCL: is_excl = 1'b1;
            default:  is_excl = 1'b0;
        endcase
    end

    assert_flush_opens_R6: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> state == MON_OPEN);
    assert_reserve_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reserve && !flush) |=> state == MON_EXCL);
    assert_consume_opens_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (consume && !reserve) |=> state == MON_OPEN);
    assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!consume && !reserve && !flush) |=> $stable(state));
endmodule

// File: rtl/excl_tag_reg.sv
module excl_tag_reg #(
    parameter int ADDR_W    = 32,
    parameter int GRAN_LOG2 = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [ADDR_W-1:0] cap_addr,
    input  logic [ADDR_W-1:0] cmp_addr,
    output logic              hit
);
    localparam int TAG_W = ADDR_W - GRAN_LOG2;

    logic [TAG_W-1:0] tag_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       tag_q <= '0;
        else if (capture) tag_q <= cap_addr[ADDR_W-1:GRAN_LOG2];
    end

    assign hit = (cmp_addr[ADDR_W-1:GRAN_LOG2] == tag_q);

    assert_tag_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(tag_q));
endmodule

// File: rtl/excl_wr_gate.sv
module excl_wr_gate #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              st_valid,
    input  logic              st_excl,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [DATA_W-1:0] st_data,
    input  logic              is_excl,
    input  logic              tag_hit,
    input  logic              kill,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              st_status_valid,
    output logic              st_status
);
    logic excl_ok;

    always_comb begin
        excl_ok         = is_excl && tag_hit && !kill;
        st_status_valid = st_valid && st_excl;
        st_status       = st_status_valid && !excl_ok;
        mem_we          = st_valid && (!st_excl || excl_ok);
        mem_addr        = st_addr;
        mem_wdata       = st_data;
    end

    always_comb begin
        if (st_status_valid) begin
            assert_status_excl_R5: assert (mem_we != st_status);
        end
    end
endmodule

// File: rtl/excl_monitor.sv
module excl_monitor
    import excl_mon_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int GRAN_LOG2 = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_excl,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic              st_valid,
    input  logic              st_excl,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [DATA_W-1:0] st_data,
    input  logic              clr_req,
    input  logic              exc_entry,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              st_status_valid,
    output logic              st_status
);
    mon_state_e state;
    logic       is_excl;
    logic       tag_hit;
    logic       flush;
    logic       excl_store;

    assign flush      = clr_req || exc_entry;
    assign excl_store = st_valid && st_excl;

    excl_mon_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .reserve (ld_excl),
        .consume (excl_store),
        .flush   (flush),
        .state   (state),
        .is_excl (is_excl)
    );

    excl_tag_reg #(.ADDR_W(ADDR_W), .GRAN_LOG2(GRAN_LOG2)) u_tag (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (ld_excl),
        .cap_addr (ld_addr),
        .cmp_addr (st_addr),
        .hit      (tag_hit)
    );

    excl_wr_gate #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_gate (
        .st_valid        (st_valid),
        .st_excl         (st_excl),
        .st_addr         (st_addr),
        .st_data         (st_data),
        .is_excl         (is_excl),
        .tag_hit         (tag_hit),
        .kill            (flush),
        .mem_we          (mem_we),
        .mem_addr        (mem_addr),
        .mem_wdata       (mem_wdata),
        .st_status_valid (st_status_valid),
        .st_status       (st_status)
    );

    assert_success_needs_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_status_valid && !st_status) |-> state == MON_EXCL);
    assert_flush_fails_store_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_status_valid && flush) |-> (st_status && !mem_we));
    assert_plain_store_writes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && !st_excl) |-> (mem_we && !st_status_valid));
endmodule

// File: tb/tb_excl_monitor.sv
module tb_excl_monitor;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int GL = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ld_excl = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic          st_valid = 1'b0;
    logic          st_excl = 1'b0;
    logic [AW-1:0] st_addr = '0;
    logic [DW-1:0] st_data = '0;
    logic          clr_req = 1'b0;
    logic          exc_entry = 1'b0;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          st_status_valid;
    logic          st_status;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    excl_monitor #(.ADDR_W(AW), .DATA_W(DW), .GRAN_LOG2(GL)) dut (
        .clk(clk), .rst_n(rst_n), .ld_excl(ld_excl), .ld_addr(ld_addr),
        .st_valid(st_valid), .st_excl(st_excl), .st_addr(st_addr), .st_data(st_data),
        .clr_req(clr_req), .exc_entry(exc_entry), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .st_status_valid(st_status_valid), .st_status(st_status)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=%0d cycles expected<100000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, got, exp);
        end
    endtask

    // Apply one cycle of stimulus after the falling edge, settle, leave outputs
    // stable for checking, then pass the rising edge.
    task automatic drive(input logic ld, input logic [AW-1:0] la,
                         input logic sv, input logic sx, input logic [AW-1:0] sa,
                         input logic [DW-1:0] sd, input logic clr, input logic exc);
        @(negedge clk);
        ld_excl = ld; ld_addr = la; st_valid = sv; st_excl = sx;
        st_addr = sa; st_data = sd; clr_req = clr; exc_entry = exc;
        #1;
    endtask

    task automatic idle();
        @(negedge clk);
        ld_excl = 0; st_valid = 0; st_excl = 0; clr_req = 0; exc_entry = 0;
    endtask

    // exclusive store check: expect success (ok=1) or failure
    task automatic xstore(input string req, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input logic ok, input logic clr, input logic exc);
        drive(0, '0, 1, 1, a, d, clr, exc);
        chk(req, {63'd0, st_status_valid}, 64'd1);
        chk(req, {63'd0, st_status}, {63'd0, !ok});
        chk(req, {63'd0, mem_we}, {63'd0, ok});
        if (ok) chk(req, {32'd0, mem_wdata}, {32'd0, d});
    endtask

    task automatic xload(input logic [AW-1:0] a);
        drive(1, a, 0, 0, '0, '0, 0, 0);
    endtask

    initial begin
        logic [AW-1:0] base;
        logic [AW-1:0] la, sa;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state open
        drive(0, '0, 0, 0, '0, '0, 0, 0);
        chk("R1 idle we", {63'd0, mem_we}, 64'd0);
        chk("R1 idle sv", {63'd0, st_status_valid}, 64'd0);
        xstore("R1 store after reset", 32'h0000_0000, 32'h11, 0, 0, 0);

        // R3/R4/R5/R8: granule sweep
        base = 32'h2000_0040;
        for (int a = 0; a < 8; a++) begin
            for (int d = -12; d <= 12; d++) begin
                la = base + a;
                sa = la + d;
                xload(la);
                xstore("R3 granule sweep", sa, 32'hA500_0000 + sa,
                       (la >> GL) == (sa >> GL), 0, 0);
                xstore("R8 reservation consumed", la, 32'h5A, 0, 0, 0);
            end
        end

        // R4: address pass-through on success
        xload(32'h0000_1238);
        drive(0, '0, 1, 1, 32'h0000_123C, 32'hDEAD_BEEF, 0, 0);
        chk("R4 mem_addr", {32'd0, mem_addr}, {32'd0, 32'h0000_123C});
        chk("R4 mem_wdata", {32'd0, mem_wdata}, {32'd0, 32'hDEAD_BEEF});
        chk("R4 we", {63'd0, mem_we}, 64'd1);

        // R2: reload while exclusive, latest tag wins
        xload(32'h0000_0100);
        xload(32'h0000_0200);
        xstore("R2 old tag rejected", 32'h0000_0100, 32'h1, 0, 0, 0);
        xload(32'h0000_0100);
        xload(32'h0000_0200);
        xstore("R2 new tag accepted", 32'h0000_0204, 32'h2, 1, 0, 0);

        // R6: clear
        xload(32'h0000_0300);
        drive(0, '0, 0, 0, '0, '0, 1, 0);
        xstore("R6 store after clear", 32'h0000_0300, 32'h3, 0, 0, 0);
        xload(32'h0000_0300);
        xstore("R6 clear same cycle", 32'h0000_0300, 32'h4, 0, 1, 0);

        // R7: exception entry
        xload(32'h0000_0400);
        drive(0, '0, 0, 0, '0, '0, 0, 1);
        xstore("R7 store after exception", 32'h0000_0400, 32'h5, 0, 0, 0);
        xload(32'h0000_0400);
        xstore("R7 exception same cycle", 32'h0000_0400, 32'h6, 0, 0, 1);
        xload(32'h0000_0400);
        drive(1, 32'h0000_0400, 0, 0, '0, '0, 0, 1);
        xstore("R7 exception beats load", 32'h0000_0400, 32'h7, 0, 0, 0);

        // R9: ordinary store writes and leaves reservation
        xload(32'h0000_0500);
        drive(0, '0, 1, 0, 32'h0000_0500, 32'h99, 0, 0);
        chk("R9 plain we", {63'd0, mem_we}, 64'd1);
        chk("R9 plain sv", {63'd0, st_status_valid}, 64'd0);
        chk("R9 plain data", {32'd0, mem_wdata}, 64'h99);
        xstore("R9 reservation kept", 32'h0000_0500, 32'h8, 1, 0, 0);
        drive(0, '0, 1, 0, 32'h0000_0600, 32'h77, 0, 0);
        chk("R9 plain while open", {63'd0, mem_we}, 64'd1);

        // R10: load and exclusive store in one cycle
        drive(1, 32'h0000_0700, 1, 1, 32'h0000_0700, 32'h9, 0, 0);
        chk("R10 store on old state", {63'd0, st_status}, 64'd1);
        chk("R10 no write", {63'd0, mem_we}, 64'd0);
        xstore("R10 load stands", 32'h0000_0700, 32'hA, 1, 0, 0);
        xload(32'h0000_0800);
        drive(1, 32'h0000_0900, 1, 1, 32'h0000_0800, 32'hB, 0, 0);
        chk("R10 old reservation used", {63'd0, st_status}, 64'd0);
        xstore("R10 new tag stands", 32'h0000_0900, 32'hC, 1, 0, 0);

        idle();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule